// File: doc/BRIEF.md
# Global Interrupt Enable and Flag Save Controller

This block is the global interrupt control of a 12-bit accumulator CPU. When the CPU finishes an instruction it raises a boundary strobe. If the instruction was an I/O instruction addressed to device 0, the block decodes the three function bits into one of eight operations. It holds the global interrupt-enable state, and turning the enable on is delayed by one instruction. Turning it off takes effect at once.

At each boundary the block reports three things. It says whether the CPU should skip the next instruction. It says whether the accumulator, link or greater-than flag must be loaded, and with what data. It also says whether the CPU may take an interrupt in place of fetching the next instruction.

The block keeps its own copy of the interrupt inhibit, user-mode, instruction-field and data-field registers. A single 12-bit word saves and restores all of these together with the link, the greater-than flag and the enable. The CPU datapath and the devices lie outside the block. The CPU reports acceptance of an interrupt on `irq_take`, and the devices supply the OR of their requests on `req_any`.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After synchronous active-low reset the enable, the pending delayed enable, inhibit, user mode, instruction field and data field are all zero, so a skip-if-enabled does not skip and a save with link, greater-than and request low returns 0.
- R2: Function 1 (enable) sets the enable, but `irq_eligible` stays low at the boundary of that instruction. Eligibility begins at the boundary of the following instruction.
- R3: Function 2 (disable) clears the enable with immediate effect: `irq_eligible` is low at its own boundary. It also cancels an enable that is still waiting to take effect.
- R4: `irq_take` at a boundary clears the enable and any pending delayed enable, even when the same instruction is an enable.
- R5: `skip` is high at a boundary for function 0 when the enable is set, for function 3 when `req_any` is high, and for function 6 when `gt_in` is high. It is low in every other case.
- R6: Function 4 (save) loads the accumulator with the packed word. From MSB to LSB the word holds: bit 11 link, bit 10 greater-than, bit 9 request pending, bit 8 inhibit, bit 7 enable, bit 6 user mode, bits 5:3 instruction field and bits 2:0 data field.
- R7: Function 5 (restore) takes link, greater-than, inhibit, user mode and both fields from `acc_in` in the R6 layout and ignores bit 9. A set bit 7 acts like function 1, with its one-instruction delay. A clear bit 7 acts like function 2.
- R8: Function 7 (clear all) loads zero into the accumulator and the link, pulses `dev_reset`, and disables interrupts with immediate effect.
- R9: `irq_eligible` is high only at a boundary where the effective enable is set, `req_any` is high and inhibit is clear.
- R10: With `insn_end` low, or with `iot_hit` low, the block raises no skip, load or reset output and its state does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_end | input | 1 | An instruction completes this cycle (instruction boundary) |
| iot_hit | input | 1 | The completing instruction is a device-0 I/O instruction |
| iot_func | input | 3 | Function bits of that instruction |
| acc_in | input | 12 | Current accumulator |
| link_in | input | 1 | Current link bit |
| gt_in | input | 1 | Greater-than flag of the arithmetic unit |
| req_any | input | 1 | OR of all device interrupt requests |
| irq_take | input | 1 | CPU accepts an interrupt at this boundary |
| skip | output | 1 | Skip the next instruction |
| acc_load | output | 1 | Load the accumulator with `acc_out` |
| acc_out | output | 12 | Accumulator load data |
| link_load | output | 1 | Load the link with `link_out` |
| link_out | output | 1 | Link load data |
| gt_load | output | 1 | Load the greater-than flag with `gt_out` |
| gt_out | output | 1 | Greater-than load data |
| dev_reset | output | 1 | One-cycle reset pulse to all devices |
| irq_eligible | output | 1 | The CPU may take an interrupt at this boundary |
| mm_inhibit | output | 1 | Interrupt inhibit flag |
| mm_user | output | 1 | User-mode flag |
| mm_if | output | 3 | Instruction field |
| mm_df | output | 3 | Data field |

## Verification
Two actions can meet at one boundary: an instruction that sets or clears the enable, and the CPU's acceptance of an interrupt. The bench provokes the clash by pulsing `irq_take` on the same boundary as an enable. It then judges the outcome from later boundaries, where no eligibility and no skip-if-enabled may appear. A second clash comes from a restore that sets both enable and inhibit while a request is present. The bench checks that the inhibit restored at that boundary holds interrupts off at the next one. Eligibility then returns only once inhibit is restored clear and the delay has run out.

// File: rtl/irq_flag_pkg.sv
// Package: shared function codes and strobe type for the device-0
// interrupt controller. Assumes a 3-bit I/O function field.
package irq_flag_pkg;

    // Device-0 function codes; the numeric values are fixed by the CPU.
    typedef enum logic [2:0] {
        FN_SKIP_ON  = 3'd0,
        FN_ENABLE   = 3'd1,
        FN_DISABLE  = 3'd2,
        FN_SKIP_REQ = 3'd3,
        FN_SAVE     = 3'd4,
        FN_RESTORE  = 3'd5,
        FN_SKIP_GT  = 3'd6,
        FN_CLEAR    = 3'd7
    } iot_fn_e;

    localparam int NUM_FN = 8;

    // One strobe per function, valid only at a device-0 boundary.
    typedef struct packed {
        logic clr_all;
        logic skip_gt;
        logic restore;
        logic save;
        logic skip_req;
        logic disable_ie;
        logic enable_ie;
        logic skip_on;
    } fn_strb_t;

endpackage

// File: rtl/irq_fn_decode.sv
// Module: turns the function bits of a device-0 I/O instruction into one
// strobe per function. Assumes insn_end and iot_hit qualify the bits.
module irq_fn_decode
    import irq_flag_pkg::*;
(
    input  logic       insn_end,
    input  logic       iot_hit,
    input  logic [2:0] iot_func,
    output fn_strb_t   strb
);
    logic             fire;
    logic [NUM_FN-1:0] hit_vec;

    assign fire = insn_end & iot_hit;

    // One comparator per function code.
    for (genvar g = 0; g < NUM_FN; g++) begin : g_fn
        assign hit_vec[g] = fire && (iot_func == 3'(g));
    end

    // Map the vector onto the named strobes (bit g is code g).
    always_comb begin
        strb = fn_strb_t'(hit_vec);
    end
endmodule

// File: rtl/irq_enable_ctl.sv
// Module: global interrupt enable with a one-instruction enable delay.
// Assumes set/clear requests are already qualified by a boundary, and that
// take is only meaningful at a boundary.
module irq_enable_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic insn_end,
    input  logic set_req,
    input  logic clr_req,
    input  logic take,
    output logic ie_q,
    output logic eff_now
);
    logic pend_q;

    // Enable state seen by the interrupt check at this boundary.
    always_comb begin
        if (clr_req)      eff_now = 1'b0;
        else if (set_req) eff_now = ie_q & ~pend_q;
        else              eff_now = ie_q;
    end

    // Update architectural enable and the pending-delay flag per boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            pend_q <= 1'b0;
        end else if (insn_end) begin
            if (clr_req || take) begin
                ie_q   <= 1'b0;
                pend_q <= 1'b0;
            end else if (set_req) begin
                ie_q   <= 1'b1;
                pend_q <= 1'b1;
            end else begin
                pend_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_flag_regs.sv
// Module: inhibit, user-mode and field registers plus packing of the save
// word. Assumes restore is a qualified strobe; fields are FLD_W wide.
module irq_flag_regs #(
    parameter int FLD_W  = 3,
    localparam int WORD_W = 6 + 2 * FLD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restore,
    input  logic              inh_new,
    input  logic              user_new,
    input  logic [FLD_W-1:0]  if_new,
    input  logic [FLD_W-1:0]  df_new,
    input  logic              link_in,
    input  logic              gt_in,
    input  logic              req_any,
    input  logic              ie_q,
    output logic              inh_q,
    output logic              user_q,
    output logic [FLD_W-1:0]  if_q,
    output logic [FLD_W-1:0]  df_q,
    output logic [WORD_W-1:0] packed_word
);
    // Load the machine-state flags from a restore word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inh_q  <= 1'b0;
            user_q <= 1'b0;
            if_q   <= '0;
            df_q   <= '0;
        end else if (restore) begin
            inh_q  <= inh_new;
            user_q <= user_new;
            if_q   <= if_new;
            df_q   <= df_new;
        end
    end

    // Assemble the save word, MSB first.
    always_comb begin
        packed_word = {link_in, gt_in, req_any, inh_q, ie_q, user_q, if_q, df_q};
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
// Module: top of the device-0 interrupt controller. Decodes the function,
// drives skip, load and reset outputs combinationally at the boundary, and
// holds enable and flag state. Assumes all inputs are valid with insn_end.
module irq_flag_ctrl
    import irq_flag_pkg::*;
#(
    parameter int FLD_W  = 3,
    localparam int WORD_W = 6 + 2 * FLD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_end,
    input  logic              iot_hit,
    input  logic [2:0]        iot_func,
    input  logic [WORD_W-1:0] acc_in,
    input  logic              link_in,
    input  logic              gt_in,
    input  logic              req_any,
    input  logic              irq_take,
    output logic              skip,
    output logic              acc_load,
    output logic [WORD_W-1:0] acc_out,
    output logic              link_load,
    output logic              link_out,
    output logic              gt_load,
    output logic              gt_out,
    output logic              dev_reset,
    output logic              irq_eligible,
    output logic              mm_inhibit,
    output logic              mm_user,
    output logic [FLD_W-1:0]  mm_if,
    output logic [FLD_W-1:0]  mm_df
);
    localparam int LINK_B = WORD_W - 1;
    localparam int GT_B   = WORD_W - 2;
    localparam int REQ_B  = WORD_W - 3;
    localparam int INH_B  = WORD_W - 4;
    localparam int IE_B   = WORD_W - 5;
    localparam int USER_B = WORD_W - 6;

    fn_strb_t          strb;
    logic              ie_q;
    logic              eff_now;
    logic              set_req;
    logic              clr_req;
    logic              take_q;
    logic [WORD_W-1:0] packed_word;
    logic              unused_req_bit;

    assign unused_req_bit = acc_in[REQ_B];

    irq_fn_decode u_dec (
        .insn_end (insn_end),
        .iot_hit  (iot_hit),
        .iot_func (iot_func),
        .strb     (strb)
    );

    // Enable requests from enable, clear-all and restore.
    always_comb begin
        set_req = strb.enable_ie | (strb.restore & acc_in[IE_B]);
        clr_req = strb.disable_ie | strb.clr_all | (strb.restore & ~acc_in[IE_B]);
        take_q  = insn_end & irq_take;
    end

    irq_enable_ctl u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .insn_end (insn_end),
        .set_req  (set_req),
        .clr_req  (clr_req),
        .take     (take_q),
        .ie_q     (ie_q),
        .eff_now  (eff_now)
    );

    irq_flag_regs #(.FLD_W(FLD_W)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .restore     (strb.restore),
        .inh_new     (acc_in[INH_B]),
        .user_new    (acc_in[USER_B]),
        .if_new      (acc_in[2*FLD_W-1:FLD_W]),
        .df_new      (acc_in[FLD_W-1:0]),
        .link_in     (link_in),
        .gt_in       (gt_in),
        .req_any     (req_any),
        .ie_q        (ie_q),
        .inh_q       (mm_inhibit),
        .user_q      (mm_user),
        .if_q        (mm_if),
        .df_q        (mm_df),
        .packed_word (packed_word)
    );

    // Skip conditions for the three test functions.
    always_comb begin
        skip = (strb.skip_on & ie_q) | (strb.skip_req & req_any) | (strb.skip_gt & gt_in);
    end

    // Register load outputs for save, restore and clear-all.
    always_comb begin
        acc_load  = strb.save | strb.clr_all;
        acc_out   = strb.save ? packed_word : '0;
        link_load = strb.restore | strb.clr_all;
        link_out  = strb.restore & acc_in[LINK_B];
        gt_load   = strb.restore;
        gt_out    = strb.restore & acc_in[GT_B];
        dev_reset = strb.clr_all;
    end

    // Interrupt eligibility at this boundary.
    always_comb begin
        irq_eligible = insn_end & eff_now & req_any & ~mm_inhibit;
    end
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
// Module: assertion checker bound to irq_flag_ctrl. Observes ports and the
// architectural enable; drives nothing.
module irq_flag_ctrl_chk #(
    parameter int FLD_W  = 3,
    localparam int WORD_W = 6 + 2 * FLD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              insn_end,
    input logic              iot_hit,
    input logic [2:0]        iot_func,
    input logic              req_any,
    input logic              irq_take,
    input logic              skip,
    input logic              acc_load,
    input logic [WORD_W-1:0] acc_out,
    input logic              link_load,
    input logic              dev_reset,
    input logic              irq_eligible,
    input logic              mm_inhibit,
    input logic              mm_user,
    input logic [FLD_W-1:0]  mm_if,
    input logic [FLD_W-1:0]  mm_df,
    input logic              ie_q
);
    AST_ELIG_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_eligible |-> (insn_end && req_any && !mm_inhibit));  // R9

    AST_DISABLE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_end && iot_hit && iot_func == 3'd2) |-> !irq_eligible);  // R3

    AST_ENABLE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_end && iot_hit && iot_func == 3'd1 && !ie_q) |-> !irq_eligible);  // R2

    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_end && irq_take) |=> !ie_q);  // R4

    AST_CLEAR_ALL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |-> (acc_load && link_load && acc_out == '0 && !irq_eligible));  // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_end |-> !(skip || acc_load || link_load || dev_reset || irq_eligible));  // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_end |=> $stable({ie_q, mm_inhibit, mm_user, mm_if, mm_df}));  // R10
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.FLD_W(FLD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .insn_end     (insn_end),
    .iot_hit      (iot_hit),
    .iot_func     (iot_func),
    .req_any      (req_any),
    .irq_take     (irq_take),
    .skip         (skip),
    .acc_load     (acc_load),
    .acc_out      (acc_out),
    .link_load    (link_load),
    .dev_reset    (dev_reset),
    .irq_eligible (irq_eligible),
    .mm_inhibit   (mm_inhibit),
    .mm_user      (mm_user),
    .mm_if        (mm_if),
    .mm_df        (mm_df),
    .ie_q         (ie_q)
);

// File: tb/irq_flag_ctrl_test.sv
// Bench: directed scenarios plus sweeps of the skip functions and of every
// restore/save word, with expected values computed from the requirements.
module irq_flag_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_end = 1'b0, iot_hit = 1'b0, link_in = 1'b0, gt_in = 1'b0;
    logic        req_any = 1'b0, irq_take = 1'b0;
    logic [2:0]  iot_func = 3'd0;
    logic [11:0] acc_in = '0;
    logic        skip, acc_load, link_load, link_out, gt_load, gt_out, dev_reset, irq_eligible;
    logic [11:0] acc_out;
    logic        mm_inhibit, mm_user;
    logic [2:0]  mm_if, mm_df;

    int checks = 0;
    int errors = 0;

    // Values captured just before the boundary edge.
    logic        c_skip, c_accld, c_lkld, c_lk, c_gtld, c_gt, c_rst, c_elig;
    logic [11:0] c_acc;

    always #5 clk = ~clk;

    irq_flag_ctrl uut (
        .clk(clk), .rst_n(rst_n), .insn_end(insn_end), .iot_hit(iot_hit),
        .iot_func(iot_func), .acc_in(acc_in), .link_in(link_in), .gt_in(gt_in),
        .req_any(req_any), .irq_take(irq_take), .skip(skip), .acc_load(acc_load),
        .acc_out(acc_out), .link_load(link_load), .link_out(link_out),
        .gt_load(gt_load), .gt_out(gt_out), .dev_reset(dev_reset),
        .irq_eligible(irq_eligible), .mm_inhibit(mm_inhibit), .mm_user(mm_user),
        .mm_if(mm_if), .mm_df(mm_df)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // One instruction: drive at negedge, capture outputs, commit at posedge.
    task automatic bnd(input logic en, input logic hit, input logic [2:0] fn,
                       input logic [11:0] ac, input logic lk, input logic g,
                       input logic rq, input logic tk);
        @(negedge clk);
        insn_end = en; iot_hit = hit; iot_func = fn; acc_in = ac;
        link_in = lk; gt_in = g; req_any = rq; irq_take = tk;
        #1;
        c_skip = skip; c_accld = acc_load; c_acc = acc_out; c_lkld = link_load;
        c_lk = link_out; c_gtld = gt_load; c_gt = gt_out; c_rst = dev_reset;
        c_elig = irq_eligible;
        @(posedge clk);
        #1;
        insn_end = 1'b0; iot_hit = 1'b0; irq_take = 1'b0;
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        check("R1 fields", {mm_inhibit, mm_user, mm_if, mm_df}, 0);
        bnd(1, 1, 3'd0, 0, 0, 0, 0, 0);
        check("R1 skon", c_skip, 0);
        bnd(1, 1, 3'd4, 0, 0, 0, 0, 0);
        check("R1 save word", c_acc, 0);

        // R5: skip sweep over enable, request, greater-than and function
        for (int ie = 0; ie < 2; ie++) begin
            bnd(1, 1, ie ? 3'd1 : 3'd2, 0, 0, 0, 0, 0);
            bnd(1, 0, 3'd0, 0, 0, 0, 0, 0);
            for (int rq = 0; rq < 2; rq++)
                for (int g = 0; g < 2; g++)
                    for (int fn = 0; fn < 8; fn++) begin
                        logic e;
                        e = (fn == 0 && ie == 1) || (fn == 3 && rq == 1) || (fn == 6 && g == 1);
                        if (fn == 1 || fn == 2 || fn == 5 || fn == 7) continue;
                        bnd(1, 1, 3'(fn), 0, 0, 1'(g), 1'(rq), 0);
                        check("R5 skip", c_skip, e);
                    end
        end

        // R2 and R4: delayed enable then acceptance
        bnd(1, 1, 3'd2, 0, 0, 0, 1, 0);
        bnd(1, 1, 3'd1, 0, 0, 0, 1, 0);
        check("R2 not at enable", c_elig, 0);
        bnd(1, 0, 3'd0, 0, 0, 0, 1, 1);
        check("R2 after next", c_elig, 1);
        bnd(1, 0, 3'd0, 0, 0, 0, 1, 0);
        check("R4 take clears", c_elig, 0);

        // R3: disable as the following instruction cancels the pending enable
        bnd(1, 1, 3'd1, 0, 0, 0, 1, 0);
        bnd(1, 1, 3'd2, 0, 0, 0, 1, 0);
        check("R3 disable now", c_elig, 0);
        bnd(1, 0, 3'd0, 0, 0, 0, 1, 0);
        check("R3 cancelled", c_elig, 0);

        // R4: acceptance in the same boundary as an enable
        bnd(1, 1, 3'd1, 0, 0, 0, 1, 1);
        check("R4 same boundary", c_elig, 0);
        bnd(1, 0, 3'd0, 0, 0, 0, 1, 0);
        check("R4 no enable later", c_elig, 0);
        bnd(1, 1, 3'd0, 0, 0, 0, 1, 0);
        check("R4 skon after take", c_skip, 0);

        // R9: eligibility needs request and boundary
        bnd(1, 1, 3'd1, 0, 0, 0, 0, 0);
        bnd(1, 0, 3'd0, 0, 0, 0, 0, 0);
        check("R9 no request", c_elig, 0);
        bnd(0, 0, 3'd0, 0, 0, 0, 1, 0);
        check("R9 no boundary", c_elig, 0);
        bnd(1, 0, 3'd0, 0, 0, 0, 1, 0);
        check("R9 all met", c_elig, 1);

        // R10: non-boundary and non-device-0 cycles change nothing
        bnd(0, 1, 3'd2, 0, 0, 0, 1, 0);
        check("R10 quiet outputs", {c_skip, c_accld, c_lkld, c_gtld, c_rst, c_elig}, 0);
        bnd(1, 0, 3'd2, 0, 0, 0, 0, 0);
        check("R10 other device", {c_skip, c_accld, c_lkld, c_gtld, c_rst}, 0);
        bnd(1, 1, 3'd0, 0, 0, 0, 0, 0);
        check("R10 enable kept", c_skip, 1);

        // R8: clear all
        bnd(1, 1, 3'd7, 12'hFFF, 1, 0, 1, 0);
        check("R8 acc load", {c_accld, c_acc}, {1'b1, 12'h000});
        check("R8 link load", {c_lkld, c_lk}, 2'b10);
        check("R8 reset pulse", c_rst, 1);
        check("R8 disabled now", c_elig, 0);
        bnd(1, 1, 3'd0, 0, 0, 0, 0, 0);
        check("R8 skon after", c_skip, 0);

        // R7 and R9: restore with inhibit, then restore clearing it
        bnd(1, 1, 3'd5, 12'h180, 0, 0, 1, 0);
        check("R7 restore delay", c_elig, 0);
        bnd(1, 0, 3'd0, 0, 0, 0, 1, 0);
        check("R9 inhibit blocks", c_elig, 0);
        bnd(1, 1, 3'd5, 12'h080, 0, 0, 1, 0);
        check("R9 old inhibit at restore", c_elig, 0);
        bnd(1, 0, 3'd0, 0, 0, 0, 1, 0);
        check("R7 enabled after restore", c_elig, 1);

        // R6 and R7: every restore word, saved back with request low
        for (int v = 0; v < 4096; v++) begin
            bnd(1, 1, 3'd5, 12'(v), 0, 0, 0, 0);
            check("R7 link and gt", {c_lkld, c_lk, c_gtld, c_gt},
                  {1'b1, 1'(v >> 11), 1'b1, 1'(v >> 10)});
            bnd(1, 1, 3'd4, 0, 1'(v >> 11), 1'(v >> 10), 0, 0);
            check("R6 save word", {c_accld, c_acc}, {1'b1, 12'(v & 12'hDFF)});
        end
        bnd(1, 1, 3'd4, 0, 0, 0, 1, 0);
        check("R6 request bit", c_acc, 12'hBFF & 12'h3FF | 12'h200);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule